// File: doc/BRIEF.md
# Multicart PRG Bank Mode Controller

This block sits on the write side of an 8-bit console CPU bus inside a multigame cartridge. It watches CPU writes and keeps five registers: a game-select (outer) register, an inner PRG register, a mirroring register, a control register and a plain data latch. From them it forms the two 16 KB program bank numbers that cover the 0x8000–0xFFFF window, and the 2-bit nametable mirroring code that the video side needs. The character bank output is tied to zero because the board uses one fixed 8 KB pattern bank.

The outer register has two unusual traits. It is loaded from the write address, not the data. It accepts a write only while the control register unlocks it. Bit 3 of the outer register picks a 32 KB layout that the data latch drives. When bit 3 is clear, bit 2 picks one of two 16 KB layouts: one takes four inner bits and one takes three. Both 16 KB layouts fix the upper half to the last bank of the selected group. Bank numbers always count in 16 KB units. In the 32 KB layout the lower half holds the even bank and the upper half holds the odd one.

There are two reset inputs. The console reset clears only the game-select register. Power-on reset clears every register. Both are asserted asynchronously and released in step with the clock.

Top module: `multicart_prg_ctrl`

## Requirements
- R1: A strobed write with address[15:13]=3'b011 loads the outer register with address[7:0], but only while bit 0 of the control register is 1. Otherwise the outer register keeps its value.
- R2: Every strobed write with address[15]=1 loads its data byte into the data latch, whatever other register the same write also loads.
- R3: A strobed write to 0x8000–0x8FFF loads the inner PRG register. In 0x9000–0x9FFF, address[3:2]=0 loads the mirroring register and address[3:2]=2 loads the control register. Address[3:2] of 1 or 3, and writes to 0xA000–0xFFFF, load none of these three registers.
- R4: With outer bit 3 set, the 32 KB bank is {outer[7:1], latch[2:0]}. The lower output is twice that value and the upper output is twice that value plus 1.
- R5: With outer bit 3 set, the mirroring output is 2 + latch[4] (single-screen, page chosen by latch bit 4).
- R6: With outer bit 3 clear and bit 2 set, the lower bank is {outer[7:1], inner[3:0]} and the upper bank is {outer[7:1], 4'hF}.
- R7: With outer bits 3 and 2 both clear, the lower bank is {outer[7:0], inner[2:0]} and the upper bank is {outer[7:0], 3'h7}.
- R8: With outer bit 3 clear, the mirroring output equals mirroring register bits [1:0] (0 vertical, 1 horizontal, 2 single lower, 3 single upper).
- R9: Console reset clears the outer register only. The inner, mirroring, control and latch values survive it.
- R10: Power-on reset clears every register, which gives lower bank 0, upper bank 7 and mirroring 0.
- R11: With the write strobe low, no register changes. The character bank output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-bus clock |
| por_n | input | 1 | Power-on reset, active low, clears all registers |
| rst_n | input | 1 | Console reset, active low, clears the outer register |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| prg_bank_lo | output | 11 | 16 KB bank for 0x8000–0xBFFF |
| prg_bank_hi | output | 11 | 16 KB bank for 0xC000–0xFFFF |
| mirror | output | 2 | Nametable mirroring code |
| chr_bank | output | 4 | 8 KB character bank, constant 0 |

## Verification
The hardest state to reach is the 32 KB layout with a latch value that differs from the inner register. To get there, the stimulus must first write the control register to unlock the outer register, then load an outer value with bit 3 set through the address bus. It must then make latch-only writes (0xC000 and above) that move the bank and the mirroring page while the inner register stays fixed. The stimulus table performs this sequence in order and follows it with a write that returns to a 16 KB layout. This shows that the inner value written earlier is still in place. Directed tests then cover a strobe-less bus cycle, the two resets separately, and an outer value of 0xFE, which checks the top bits of the bank numbers.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MAP_NARROW16 = 2'd0,
    MAP_WIDE16   = 2'd1,
    MAP_FULL32   = 2'd2
  } map_mode_e;

  localparam logic [2:0] WIN_OUTER = 3'b011;
  localparam logic [3:0] PAGE_INNER = 4'h8;
  localparam logic [3:0] PAGE_CTRL  = 4'h9;
  localparam logic [1:0] SUB_MIRR   = 2'd0;
  localparam logic [1:0] SUB_MISC   = 2'd2;
endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign sync_n = stage_q[1];
endmodule

// File: rtl/mc_reg_file.sv
module mc_reg_file #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 8
) (
  input  logic               clk,
  input  logic               sys_rst_n,
  input  logic               outer_rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  input  logic               wr,
  output logic [OUTER_W-1:0] outer_q,
  output logic [DATA_W-1:0]  inner_q,
  output logic [DATA_W-1:0]  mirr_q,
  output logic [DATA_W-1:0]  misc_q,
  output logic [DATA_W-1:0]  latch_q
);
  import mc_pkg::*;

  localparam int TOP = ADDR_W - 1;

  logic hit_outer, hit_rom, hit_inner, hit_mirr, hit_misc;
  logic [OUTER_W-1:0] outer_d;
  logic [DATA_W-1:0]  inner_d, mirr_d, misc_d, latch_d;

  always_comb begin
    hit_outer = wr && (addr[TOP -: 3] == WIN_OUTER) && misc_q[0];
    hit_rom   = wr && addr[TOP];
    hit_inner = hit_rom && (addr[TOP -: 4] == PAGE_INNER);
    hit_mirr  = hit_rom && (addr[TOP -: 4] == PAGE_CTRL) && (addr[3:2] == SUB_MIRR);
    hit_misc  = hit_rom && (addr[TOP -: 4] == PAGE_CTRL) && (addr[3:2] == SUB_MISC);

    outer_d = hit_outer ? addr[OUTER_W-1:0] : outer_q;
    inner_d = hit_inner ? data : inner_q;
    mirr_d  = hit_mirr  ? data : mirr_q;
    misc_d  = hit_misc  ? data : misc_q;
    latch_d = hit_rom   ? data : latch_q;
  end

  always_ff @(posedge clk or negedge outer_rst_n) begin
    if (!outer_rst_n) outer_q <= '0;
    else if (hit_outer) outer_q <= outer_d;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      inner_q <= '0;
      mirr_q  <= '0;
      misc_q  <= '0;
      latch_q <= '0;
    end else begin
      if (hit_inner) inner_q <= inner_d;
      if (hit_mirr)  mirr_q  <= mirr_d;
      if (hit_misc)  misc_q  <= misc_d;
      if (hit_rom)   latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/mc_bank_map.sv
module mc_bank_map #(
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 8,
  parameter int BANK_W  = OUTER_W + 3
) (
  input  logic [OUTER_W-1:0] outer,
  input  logic [DATA_W-1:0]  inner,
  input  logic [DATA_W-1:0]  mirr,
  input  logic [DATA_W-1:0]  latch,
  output mc_pkg::map_mode_e  mode,
  output logic [BANK_W-1:0]  bank_lo,
  output logic [BANK_W-1:0]  bank_hi,
  output logic [1:0]         mirror
);
  import mc_pkg::*;

  localparam int WIDE_W   = 4;
  localparam int NARROW_W = 3;
  localparam int FULL_W   = 3;

  logic [BANK_W-2:0] bank32;

  always_comb begin
    if (outer[3])      mode = MAP_FULL32;
    else if (outer[2]) mode = MAP_WIDE16;
    else               mode = MAP_NARROW16;

    bank32  = {outer[OUTER_W-1:1], latch[FULL_W-1:0]};
    bank_lo = '0;
    bank_hi = '0;
    mirror  = mirr[1:0];
    unique case (mode)
      MAP_FULL32: begin
        bank_lo = {bank32, 1'b0};
        bank_hi = {bank32, 1'b1};
        mirror  = {1'b1, latch[4]};
      end
      MAP_WIDE16: begin
        bank_lo = {outer[OUTER_W-1:1], inner[WIDE_W-1:0]};
        bank_hi = {outer[OUTER_W-1:1], {WIDE_W{1'b1}}};
      end
      default: begin
        bank_lo = {outer, inner[NARROW_W-1:0]};
        bank_hi = {outer, {NARROW_W{1'b1}}};
      end
    endcase
  end
endmodule

// File: rtl/multicart_prg_ctrl.sv
module multicart_prg_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 8,
  parameter int CHR_W   = 4,
  parameter int BANK_W  = OUTER_W + 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  output logic [BANK_W-1:0] prg_bank_lo,
  output logic [BANK_W-1:0] prg_bank_hi,
  output logic [1:0]        mirror,
  output logic [CHR_W-1:0]  chr_bank
);
  logic por_q_n, con_q_n, outer_q_n;
  logic [OUTER_W-1:0] outer_q;
  logic [DATA_W-1:0]  inner_q, mirr_q, misc_q, latch_q;
  mc_pkg::map_mode_e  mode;

  mc_rst_sync u_por_sync (.clk(clk), .arst_n(por_n), .sync_n(por_q_n));
  mc_rst_sync u_con_sync (.clk(clk), .arst_n(rst_n), .sync_n(con_q_n));

  assign outer_q_n = por_q_n & con_q_n;

  mc_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUTER_W(OUTER_W)) u_regs (
    .clk(clk), .sys_rst_n(por_q_n), .outer_rst_n(outer_q_n),
    .addr(cpu_addr), .data(cpu_data), .wr(cpu_wr),
    .outer_q(outer_q), .inner_q(inner_q), .mirr_q(mirr_q),
    .misc_q(misc_q), .latch_q(latch_q)
  );

  mc_bank_map #(.DATA_W(DATA_W), .OUTER_W(OUTER_W), .BANK_W(BANK_W)) u_map (
    .outer(outer_q), .inner(inner_q), .mirr(mirr_q), .latch(latch_q),
    .mode(mode), .bank_lo(prg_bank_lo), .bank_hi(prg_bank_hi), .mirror(mirror)
  );

  assign chr_bank = '0;
endmodule

// File: rtl/mc_prg_checker.sv
module mc_prg_checker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 8,
  parameter int BANK_W  = OUTER_W + 3
) (
  input logic               clk,
  input logic               sys_n,
  input logic               outer_n,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic [DATA_W-1:0]  cpu_data,
  input logic               cpu_wr,
  input logic [OUTER_W-1:0] outer_q,
  input logic [DATA_W-1:0]  misc_q,
  input logic [DATA_W-1:0]  latch_q,
  input logic [BANK_W-1:0]  prg_bank_lo,
  input logic [BANK_W-1:0]  prg_bank_hi,
  input logic [1:0]         mirror
);
  AST_OUTER_LOCKED: assert property (@(posedge clk) disable iff (!outer_n)
    (cpu_wr && cpu_addr[ADDR_W-1 -: 3] == 3'b011 && !misc_q[0]) |=> $stable(outer_q)); // R1
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!sys_n)
    (cpu_wr && cpu_addr[ADDR_W-1]) |=> (latch_q == $past(cpu_data))); // R2
  AST_FULL32_PAIR: assert property (@(posedge clk) disable iff (!sys_n)
    outer_q[3] |-> (prg_bank_hi == prg_bank_lo + 1'b1)); // R4
  AST_FULL32_SINGLE: assert property (@(posedge clk) disable iff (!sys_n)
    outer_q[3] |-> (mirror == {1'b1, latch_q[4]})); // R5
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!sys_n)
    (outer_q[3:2] == 2'b00) |-> (prg_bank_hi[2:0] == 3'b111)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!outer_n)
    !cpu_wr |=> ($stable(prg_bank_lo) && $stable(prg_bank_hi) && $stable(mirror))); // R11
endmodule

bind multicart_prg_ctrl mc_prg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUTER_W(OUTER_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .sys_n(por_q_n), .outer_n(outer_q_n),
  .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
  .outer_q(outer_q), .misc_q(misc_q), .latch_q(latch_q),
  .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi), .mirror(mirror)
);

// File: tb/tb_multicart_prg_ctrl.sv
`timescale 1ns/1ps
module tb_multicart_prg_ctrl;
  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_wr;
  logic [10:0] prg_bank_lo, prg_bank_hi;
  logic [1:0]  mirror;
  logic [3:0]  chr_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  multicart_prg_ctrl dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi),
    .mirror(mirror), .chr_bank(chr_bank)
  );

  // {addr, data, expected lo, expected hi, expected mirror}
  localparam int NVEC = 14;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h6055, 8'h00, 11'h000, 11'h007, 2'd0},
    {16'h9008, 8'h01, 11'h000, 11'h007, 2'd0},
    {16'h6003, 8'h00, 11'h018, 11'h01F, 2'd0},
    {16'h8000, 8'h0D, 11'h01D, 11'h01F, 2'd0},
    {16'h9000, 8'h01, 11'h01D, 11'h01F, 2'd1},
    {16'h9004, 8'h03, 11'h01D, 11'h01F, 2'd1},
    {16'h6006, 8'h00, 11'h03D, 11'h03F, 2'd1},
    {16'h6009, 8'h00, 11'h046, 11'h047, 2'd2},
    {16'hC000, 8'h15, 11'h04A, 11'h04B, 2'd3},
    {16'h9000, 8'h02, 11'h044, 11'h045, 2'd2},
    {16'h6002, 8'h00, 11'h015, 11'h017, 2'd2},
    {16'h9008, 8'h00, 11'h015, 11'h017, 2'd2},
    {16'h60FF, 8'h00, 11'h015, 11'h017, 2'd2},
    {16'h9000, 8'h03, 11'h015, 11'h017, 2'd3}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R1 locked outer";
      1:  return "R3 control write";
      2:  return "R1 R7 outer load";
      3:  return "R3 R7 inner load";
      4:  return "R8 mirroring";
      5:  return "R3 unmapped sub";
      6:  return "R6 wide 16K";
      7:  return "R4 R5 full 32K";
      8:  return "R2 R5 latch only";
      9:  return "R2 R4 latch via 9000";
      10: return "R7 R8 back to narrow";
      11: return "R3 relock";
      12: return "R1 locked again";
      default: return "R8 mirror upper";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic chk_out(input string tag, input int lo, input int hi, input int mi);
    chk({tag, " lo"}, int'(prg_bank_lo), lo);
    chk({tag, " hi"}, int'(prg_bank_hi), hi);
    chk({tag, " mirror"}, int'(mirror), mi);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0;
    cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk_out("R10 power-up state", 'h000, 'h007, 0);
    chk("R11 chr bank", int'(chr_bank), 0);

    for (int i = 0; i < NVEC; i++) begin
      cpu_write(VEC[i][47:32], VEC[i][31:24]);
      chk_out(vec_tag(i), int'(VEC[i][23:13]), int'(VEC[i][12:2]), int'(VEC[i][1:0]));
    end

    // R11: bus activity without strobe
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h07;
    repeat (2) @(negedge clk);
    cpu_addr = 16'h9000; cpu_data = 8'h00;
    repeat (2) @(negedge clk);
    chk_out("R11 no strobe", 'h015, 'h017, 3);

    // R9: console reset clears outer only (inner 0x0D, mirroring 3 remain)
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_out("R9 console reset", 'h005, 'h007, 3);

    // R10: power-on reset clears all
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_out("R10 power reset", 'h000, 'h007, 0);
    cpu_write(16'h6009, 8'h00);
    chk_out("R10 R1 control cleared", 'h000, 'h007, 0);

    // R4: top outer bits reach the bank numbers
    cpu_write(16'h9008, 8'h01);
    cpu_write(16'h8000, 8'h07);
    cpu_write(16'h60FE, 8'h00);
    chk_out("R4 R5 outer FE", 'h7FE, 'h7FF, 2);
    chk("R11 chr bank late", int'(chr_bank), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule